// File: doc/BRIEF.md
# Utilization-Driven Performance Level Governor

This block selects one of `NUM_LEVELS` ordered clock performance levels (index 0 is the slowest) from a utilization figure. A programmable period counter produces a sampling tick, and the selected policy makes one decision on each tick. Five policies are available. Two fixed policies pin the level to the top or bottom of the allowed range. A manual policy follows a level written by the user. A burst policy jumps to the top on high load and otherwise drifts down. A gradual policy walks up or down one step at a time using two thresholds.

The allowed range is set at run time by a floor and a ceiling. Every level the block drives is saturated into that range. The output is the current level index and a one-cycle strobe that marks each change. The clock switching itself is left to the logic that consumes the index.

Top module: `freq_governor`

## Requirements
- R1: While `rst_n` is low (synchronous reset), `level_o` takes the effective ceiling and `change_o` is 0.
- R2: A decision is taken only on a sampling tick. The tick fires once every `period_i` cycles, and a period of 0 or 1 gives a tick on every cycle. With `period_i` = P held through reset, the first decision appears after the P-th rising edge following reset release. Between ticks the level moves only to stay inside the allowed range.
- R3: Policy code 0 (pinned high) selects the effective ceiling.
- R4: Policy code 1 (pinned low) selects the effective floor.
- R5: Policy code 2 (manual) selects `user_lvl_i`, saturated into the allowed range.
- R6: Policy code 3 (burst) selects the ceiling when `util_i` is strictly above `up_thr_i`. Otherwise it lowers the level by one step, and never below the floor.
- R7: Policy code 4 (gradual) raises the level by one when `util_i` is strictly above `up_thr_i`. It lowers the level by one when `util_i` is strictly below `down_thr_i`. Otherwise it leaves the level unchanged. The result stays within the allowed range.
- R8: The effective ceiling is `lvl_max_i` limited to `NUM_LEVELS-1`. The effective floor is `lvl_min_i`, or the ceiling when `lvl_min_i` exceeds it. `level_o` is forced into [floor, ceiling] on every cycle, tick or not.
- R9: `change_o` is high for exactly the cycles in which `level_o` differs from its value in the previous cycle.
- R10: Policy codes 5 to 7 keep the current level, apart from the range saturation of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| util_i | input | UTIL_W | Utilization sample |
| policy_i | input | 3 | Policy code (0 high, 1 low, 2 manual, 3 burst, 4 gradual, 5..7 hold) |
| up_thr_i | input | UTIL_W | Upper utilization threshold |
| down_thr_i | input | UTIL_W | Lower utilization threshold (gradual policy) |
| period_i | input | PER_W | Sampling period in cycles |
| lvl_min_i | input | LVL_W | Floor of the allowed range |
| lvl_max_i | input | LVL_W | Ceiling of the allowed range |
| user_lvl_i | input | LVL_W | Manually requested level |
| level_o | output | LVL_W | Current level index |
| change_o | output | 1 | One-cycle strobe on a level change |

## Verification
The hardest behaviour to reach is the saturation of a level between ticks, because with a short period every cycle is a tick. The stimulus sets a long period, so several cycles pass with no tick, and then lowers the ceiling below the current level. The level must then move with no policy decision behind it. The first-tick timing is pinned down by holding the period through reset and counting edges from reset release. A floor above the ceiling is forced directly on the range inputs.

// File: rtl/gov_pkg.sv
package gov_pkg;
   typedef enum logic [2:0] {
      POL_HIGH    = 3'd0,
      POL_LOW     = 3'd1,
      POL_MANUAL  = 3'd2,
      POL_BURST   = 3'd3,
      POL_GRADUAL = 3'd4
   } gov_policy_e;
endpackage

// File: rtl/gov_tick_gen.sv
module gov_tick_gen #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PER_W-1:0] period_i,
   output logic             tick_o
);
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] last_c;

   always_comb begin
      last_c = (period_i == '0) ? '0 : period_i - PER_W'(1);
      tick_o = (cnt_q >= last_c);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + PER_W'(1);
   end

   // R2: with a fixed period above one, ticks never come back to back
   assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick_o) && $past(period_i) == period_i && period_i > PER_W'(1)) |-> !tick_o);
endmodule

// File: rtl/gov_range.sv
module gov_range #(
   parameter int NUM_LEVELS = 8,
   parameter int LVL_W      = 3
) (
   input  logic [LVL_W-1:0] lvl_min_i,
   input  logic [LVL_W-1:0] lvl_max_i,
   output logic [LVL_W-1:0] floor_o,
   output logic [LVL_W-1:0] ceil_o
);
   localparam logic [LVL_W-1:0] TOP = LVL_W'(NUM_LEVELS - 1);

   generate
      if (NUM_LEVELS == (1 << LVL_W)) begin : g_full
         assign ceil_o = lvl_max_i;
      end else begin : g_partial
         assign ceil_o = (lvl_max_i > TOP) ? TOP : lvl_max_i;
      end
   endgenerate

   assign floor_o = (lvl_min_i > ceil_o) ? ceil_o : lvl_min_i;
endmodule

// File: rtl/gov_policy.sv
module gov_policy
   import gov_pkg::*;
#(
   parameter int LVL_W  = 3,
   parameter int UTIL_W = 8
) (
   input  logic [2:0]        policy_i,
   input  logic [UTIL_W-1:0] util_i,
   input  logic [UTIL_W-1:0] up_thr_i,
   input  logic [UTIL_W-1:0] down_thr_i,
   input  logic [LVL_W-1:0]  user_lvl_i,
   input  logic [LVL_W-1:0]  cur_i,
   input  logic [LVL_W-1:0]  floor_i,
   input  logic [LVL_W-1:0]  ceil_i,
   output logic [LVL_W-1:0]  decide_o,
   output logic [LVL_W-1:0]  keep_o
);
   logic [LVL_W:0] raw_c;
   logic [LVL_W:0] dec_c;
   logic [LVL_W:0] inc_c;
   logic           over_c;
   logic           under_c;

   function automatic logic [LVL_W-1:0] fit(input logic [LVL_W:0] v,
                                            input logic [LVL_W-1:0] lo,
                                            input logic [LVL_W-1:0] hi);
      if (v < {1'b0, lo})      return lo;
      else if (v > {1'b0, hi}) return hi;
      else                     return v[LVL_W-1:0];
   endfunction

   always_comb begin
      over_c  = (util_i > up_thr_i);
      under_c = (util_i < down_thr_i);
      inc_c   = {1'b0, cur_i} + (LVL_W+1)'(1);
      dec_c   = (cur_i == '0) ? '0 : {1'b0, cur_i} - (LVL_W+1)'(1);
      case (gov_policy_e'(policy_i))
         POL_HIGH:    raw_c = {1'b0, ceil_i};
         POL_LOW:     raw_c = {1'b0, floor_i};
         POL_MANUAL:  raw_c = {1'b0, user_lvl_i};
         POL_BURST:   raw_c = over_c ? {1'b0, ceil_i} : dec_c;
         POL_GRADUAL: raw_c = over_c ? inc_c : (under_c ? dec_c : {1'b0, cur_i});
         default:     raw_c = {1'b0, cur_i};
      endcase
      decide_o = fit(raw_c, floor_i, ceil_i);
      keep_o   = fit({1'b0, cur_i}, floor_i, ceil_i);
   end
endmodule

// File: rtl/freq_governor.sv
module freq_governor #(
   parameter int NUM_LEVELS = 8,
   parameter int LVL_W      = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
   parameter int UTIL_W     = 8,
   parameter int PER_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [UTIL_W-1:0] util_i,
   input  logic [2:0]        policy_i,
   input  logic [UTIL_W-1:0] up_thr_i,
   input  logic [UTIL_W-1:0] down_thr_i,
   input  logic [PER_W-1:0]  period_i,
   input  logic [LVL_W-1:0]  lvl_min_i,
   input  logic [LVL_W-1:0]  lvl_max_i,
   input  logic [LVL_W-1:0]  user_lvl_i,
   output logic [LVL_W-1:0]  level_o,
   output logic              change_o
);
   generate
      if (NUM_LEVELS < 2) begin : g_bad_levels
         $error("freq_governor: NUM_LEVELS must be at least 2");
      end
      if ((1 << LVL_W) < NUM_LEVELS) begin : g_bad_lvl_w
         $error("freq_governor: LVL_W too narrow for NUM_LEVELS");
      end
      if (UTIL_W < 1 || PER_W < 1) begin : g_bad_widths
         $error("freq_governor: UTIL_W and PER_W must be positive");
      end
   endgenerate

   logic             tick;
   logic [LVL_W-1:0] floor_c;
   logic [LVL_W-1:0] ceil_c;
   logic [LVL_W-1:0] decide_c;
   logic [LVL_W-1:0] keep_c;
   logic [LVL_W-1:0] next_c;

   gov_tick_gen #(.PER_W(PER_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .period_i(period_i), .tick_o(tick)
   );

   gov_range #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_range (
      .lvl_min_i(lvl_min_i), .lvl_max_i(lvl_max_i),
      .floor_o(floor_c), .ceil_o(ceil_c)
   );

   gov_policy #(.LVL_W(LVL_W), .UTIL_W(UTIL_W)) u_policy (
      .policy_i(policy_i), .util_i(util_i), .up_thr_i(up_thr_i),
      .down_thr_i(down_thr_i), .user_lvl_i(user_lvl_i), .cur_i(level_o),
      .floor_i(floor_c), .ceil_i(ceil_c), .decide_o(decide_c), .keep_o(keep_c)
   );

   assign next_c = tick ? decide_c : keep_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_o  <= ceil_c;
         change_o <= 1'b0;
      end else begin
         level_o  <= next_c;
         change_o <= (next_c != level_o);
      end
   end

   // R8: the level always lies within the range seen on the previous cycle
   assert_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      level_o >= $past(floor_c) && level_o <= $past(ceil_c));

   // R9: the strobe marks exactly the cycles with a new level
   assert_change_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      change_o == (level_o != $past(level_o)));

   // R2: without a tick an in-range level stays put
   assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(tick) && $past(level_o) >= $past(floor_c) && $past(level_o) <= $past(ceil_c))
      |-> $stable(level_o));

   // R7: the gradual policy moves at most one step per decision
   assert_gradual_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick) && $past(policy_i) == 3'd4 &&
       $past(level_o) >= $past(floor_c) && $past(level_o) <= $past(ceil_c))
      |-> ({1'b0, level_o} <= {1'b0, $past(level_o)} + (LVL_W+1)'(1) &&
           {1'b0, $past(level_o)} <= {1'b0, level_o} + (LVL_W+1)'(1)));

   // R3: a decision under the pinned-high policy lands on the ceiling
   assert_high_policy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick) && $past(policy_i) == 3'd0) |-> level_o == $past(ceil_c));
endmodule

// File: tb/tb_freq_governor.sv
module tb_freq_governor;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] util;
   logic [2:0] policy;
   logic [7:0] up_thr;
   logic [7:0] down_thr;
   logic [15:0] period;
   logic [2:0] lvl_min;
   logic [2:0] lvl_max;
   logic [2:0] user_lvl;
   logic [2:0] level;
   logic       change;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   freq_governor dut (
      .clk(clk), .rst_n(rst_n), .util_i(util), .policy_i(policy),
      .up_thr_i(up_thr), .down_thr_i(down_thr), .period_i(period),
      .lvl_min_i(lvl_min), .lvl_max_i(lvl_max), .user_lvl_i(user_lvl),
      .level_o(level), .change_o(change)
   );

   task automatic chk(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   task automatic adv(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_and_tick();
      rst_n = 1'b0; policy = 3'd1; period = 16'd4; lvl_min = 3'd1; lvl_max = 3'd6;
      up_thr = 8'd150; down_thr = 8'd50; util = 8'd0; user_lvl = 3'd0;
      adv(5);
      chk("R1 reset level", level, 6);
      chk("R1 reset strobe", change, 0);
      rst_n = 1'b1;
      adv(3);
      chk("R2 no decision before tick", level, 6);
      adv(1);
      chk("R2 R4 first tick low policy", level, 1);
      chk("R9 strobe on change", change, 1);
      adv(1);
      chk("R9 strobe one cycle", change, 0);
      period = 16'd1;
   endtask

   task automatic t_high();
      policy = 3'd0; adv(1);
      chk("R3 high policy", level, 6);
      chk("R9 strobe high", change, 1);
      adv(1);
      chk("R9 no strobe steady", change, 0);
   endtask

   task automatic t_manual();
      policy = 3'd2; user_lvl = 3'd3; adv(1);
      chk("R5 manual in range", level, 3);
      user_lvl = 3'd7; adv(1);
      chk("R5 manual above ceiling", level, 6);
      user_lvl = 3'd0; adv(1);
      chk("R5 manual below floor", level, 1);
   endtask

   task automatic t_burst();
      policy = 3'd3; util = 8'd200; adv(1);
      chk("R6 burst jump", level, 6);
      util = 8'd150; adv(1);
      chk("R6 burst equal threshold steps down", level, 5);
      util = 8'd10; adv(1);
      chk("R6 burst step down", level, 4);
      adv(5);
      chk("R6 burst stops at floor", level, 1);
      chk("R6 burst floor no strobe", change, 0);
   endtask

   task automatic t_gradual();
      policy = 3'd2; user_lvl = 3'd3; adv(1);
      policy = 3'd4; util = 8'd200; adv(1);
      chk("R7 gradual up one", level, 4);
      adv(1);
      chk("R7 gradual up again", level, 5);
      adv(2);
      chk("R7 gradual stops at ceiling", level, 6);
      util = 8'd100; adv(3);
      chk("R7 gradual between thresholds", level, 6);
      chk("R7 gradual between no strobe", change, 0);
      util = 8'd50; adv(1);
      chk("R7 gradual equal down threshold holds", level, 6);
      util = 8'd20; adv(1);
      chk("R7 gradual down one", level, 5);
      adv(6);
      chk("R7 gradual stops at floor", level, 1);
      util = 8'd151; adv(1);
      chk("R7 gradual just above up", level, 2);
   endtask

   task automatic t_range_and_hold();
      policy = 3'd0; adv(1);
      policy = 3'd5; util = 8'd0; adv(2);
      chk("R10 hold code 5", level, 6);
      chk("R10 hold no strobe", change, 0);
      lvl_max = 3'd4; adv(1);
      chk("R8 ceiling lowered", level, 4);
      chk("R9 strobe on saturation", change, 1);
      policy = 3'd6; lvl_min = 3'd5; lvl_max = 3'd3; adv(1);
      chk("R8 floor above ceiling", level, 3);
      policy = 3'd1; adv(1);
      chk("R8 R4 floor follows ceiling", level, 3);
      policy = 3'd7; lvl_min = 3'd1; lvl_max = 3'd6; util = 8'd255; adv(2);
      chk("R10 hold code 7", level, 3);
   endtask

   task automatic t_between_ticks();
      period = 16'd1000; policy = 3'd0; adv(3);
      chk("R2 long period no decision", level, 3);
      lvl_max = 3'd2; adv(1);
      chk("R8 saturation without tick", level, 2);
   endtask

   initial begin
      t_reset_and_tick();
      t_high();
      t_manual();
      t_burst();
      t_gradual();
      t_range_and_hold();
      t_between_ticks();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule